// File: doc/BRIEF.md
# Evicted-Block Side Buffer

This block sits beside a direct-mapped or low-associativity cache and keeps the blocks that cache has just thrown out. Every eviction from the cache is pushed in through the insert port together with its block address, payload and dirty flag. When the cache misses, it probes the buffer with the missing block address before it asks the next level. All valid entries are compared in parallel against the full block address. A hit returns the payload and dirty flag in the same cycle and hands the block back to the cache. The buffer is a pool shared by every set of the cache, so a few sets that thrash can use all of its slots.

A hit and the cache's newly displaced block are handled as one swap: the incoming block takes the slot the hit block leaves. When an insert finds every slot occupied, the entry that has been resident longest is pushed out. A swap counts as a fresh arrival for this ordering. A dirty block pushed out is parked in a single write-back register with a valid/ready handshake to the next level, and clean ones are discarded. Inserts stall while that register is occupied. A probe that matches the parked block takes it back and withdraws the write-back.

Top module: `victim_store`

## Requirements
- R1: After a synchronous active-low reset the buffer is empty: any probe misses, `ins_ready` is high and `wb_valid` is low.
- R2: A probe (`probe_valid` high) compares its full block address with every valid entry in the same cycle. On a match `probe_hit` is 1 and `probe_data`/`probe_dirty` carry that entry. On no match all three are 0. At most one entry ever matches.
- R3: A probe hit without an accepted insert in that cycle removes the entry at the clock edge, so a repeated probe of that address misses.
- R4: An insert is accepted when `ins_valid` and `ins_ready` are both high. The block is stored and can later be found by a probe. Up to ENTRIES (default 8) blocks are held at once.
- R5: A probe hit and an accepted insert in the same cycle form a swap. The incoming block takes the hit entry's slot, nothing is pushed out even when the buffer is full, and every other entry stays resident.
- R6: An accepted insert that is not a swap uses a free slot when one exists. Only when every slot is valid does it push out the entry inserted longest ago, where a swap-in counts as the newest insertion.
- R7: A pushed-out entry marked dirty appears on `wb_valid`/`wb_addr`/`wb_data` and stays there unchanged until `wb_ready` is seen high. A pushed-out clean entry is dropped and `wb_valid` stays low.
- R8: `ins_ready` is low while a write-back is pending. An insert offered then is not taken and leaves the buffer contents unchanged.
- R9: A probe whose address equals the pending write-back returns that block with `probe_hit`=1 and `probe_dirty`=1. The write-back is withdrawn, so `wb_valid` is low and `ins_ready` high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Evicted block offered by the cache |
| ins_ready | output | 1 | Buffer can take an insert this cycle |
| ins_addr | input | ADDR_W | Block address of the evicted block |
| ins_data | input | DATA_W | Payload of the evicted block |
| ins_dirty | input | 1 | Evicted block differs from the next level |
| probe_valid | input | 1 | Cache miss lookup request |
| probe_addr | input | ADDR_W | Block address of the miss |
| probe_hit | output | 1 | Block found in an entry or in the write-back register |
| probe_data | output | DATA_W | Payload of the found block, 0 on a miss |
| probe_dirty | output | 1 | Dirty flag of the found block, 0 on a miss |
| wb_valid | output | 1 | A dirty pushed-out block awaits the next level |
| wb_ready | input | 1 | Next level accepts the write-back |
| wb_addr | output | ADDR_W | Block address of the write-back |
| wb_data | output | DATA_W | Payload of the write-back |

## Verification
Directed sequences first fill the buffer and drain it by probes, which separates the parallel compare from removal. They then overfill it with alternating clean and dirty blocks, which shows that age order picks the victim and that cleanliness decides whether a write-back appears. Holding `wb_ready` low while offering inserts and probing the parked address separates the stall from the withdrawal path. A swap on a full buffer followed by two more inserts shows that the swapped-in block became the newest. A long pseudo-random phase over a small address pool then mixes probes, inserts, swaps and irregular `wb_ready`, so free-slot reuse and rank compaction meet in orders no directed test lists.

// File: rtl/victim_store_pkg.sv
// Shared definitions for the evicted-block side buffer.
// Assumes nothing beyond being compiled before the modules that import it.
package victim_store_pkg;

    // Where an accepted insert lands in the entry array
    typedef enum logic [1:0] {
        PLACE_NONE   = 2'd0,
        PLACE_FREE   = 2'd1,
        PLACE_SWAP   = 2'd2,
        PLACE_OLDEST = 2'd3
    } place_e;

endpackage

// File: rtl/vs_pick.sv
// Lowest-index picker: reports whether any bit of a request vector is set
// and the index of the lowest set bit.
// Assumes ENTRIES >= 2.
module vs_pick #(
    parameter int ENTRIES = 8
) (
    input  logic [ENTRIES-1:0]         vec,
    output logic                       found,
    output logic [$clog2(ENTRIES)-1:0] idx
);
    localparam int IDX_W = $clog2(ENTRIES);

    // Scan from the top so the lowest set bit is the last to write
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vs_match.sv
// Parallel address compare: one comparator per entry against the probe key,
// a match vector, and its encoded index.
// Assumes the owner never stores the same block address in two valid entries.
module vs_match #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 26
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ENTRIES-1:0]         valid,
    input  logic [ADDR_W-1:0]          tags [ENTRIES],
    input  logic [ADDR_W-1:0]          key,
    output logic [ENTRIES-1:0]         match,
    output logic                       any,
    output logic [$clog2(ENTRIES)-1:0] idx
);
    localparam int IDX_W = $clog2(ENTRIES);

    // One comparator per entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    assign any = |match;

    // OR-encode the match vector (valid because it is at most one-hot)
    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) idx = idx | IDX_W'(i);
        end
    end

    AST_MATCH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R2
endmodule

// File: rtl/vs_order.sv
// Insertion-age tracker. Each valid entry holds a dense rank: 0 is the newest,
// count-1 the oldest. A push makes a slot newest, and a pop closes the gap it
// leaves. The oldest entry is flagged when the rank reaches ENTRIES-1.
// Assumes push and pop are never asserted together.
module vs_order #(
    parameter int ENTRIES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ENTRIES-1:0]         valid,
    input  logic                       push,
    input  logic [$clog2(ENTRIES)-1:0] push_slot,
    input  logic                       pop,
    input  logic [$clog2(ENTRIES)-1:0] pop_slot,
    output logic [ENTRIES-1:0]         oldest_vec
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int RK_W  = IDX_W + 1;

    logic [IDX_W-1:0] rank [ENTRIES];
    logic [RK_W-1:0]  push_limit;
    logic [IDX_W-1:0] pop_rank;

    // Ranks below this value age by one on a push (free slot: all of them)
    always_comb begin
        push_limit = valid[push_slot] ? {1'b0, rank[push_slot]} : RK_W'(ENTRIES);
        pop_rank   = rank[pop_slot];
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_rank
        // Per-entry rank update on push or pop
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rank[g] <= '0;
            end else if (push && (push_slot == IDX_W'(g))) begin
                rank[g] <= '0;
            end else if (push && valid[g] && ({1'b0, rank[g]} < push_limit)) begin
                rank[g] <= rank[g] + 1'b1;
            end else if (pop && valid[g] && (rank[g] > pop_rank)) begin
                rank[g] <= rank[g] - 1'b1;
            end
        end

        assign oldest_vec[g] = valid[g] && (rank[g] == IDX_W'(ENTRIES - 1));

        AST_RANK_DENSE: assert property (@(posedge clk) disable iff (!rst_n)
            valid[g] |-> (int'(rank[g]) < $countones(valid))); // R6
    end

    AST_OLDEST_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid) |-> $onehot(oldest_vec)); // R6
endmodule

// File: rtl/vs_holding.sv
// Single write-back register toward the next level with a valid/ready
// handshake. It loads a dirty pushed-out block, and a matching probe may
// withdraw it.
// Assumes the owner only loads while the register is empty.
module vs_holding #(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              cancel,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);
    // Occupancy: set on load, cleared by handshake or withdrawal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
        end else if (cancel || out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Payload capture on load
    always_ff @(posedge clk) begin
        if (load) begin
            out_addr <= load_addr;
            out_data <= load_data;
        end
    end

    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !out_valid); // R8

    AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !cancel) |=>
            (out_valid && $stable(out_addr) && $stable(out_data))); // R7
endmodule

// File: rtl/victim_store.sv
// Evicted-block side buffer. It holds ENTRIES fully associative blocks shared
// by all sets of a small cache, answers miss probes in the same cycle, swaps a
// hit block for the cache's new victim, pushes out by insertion age, and parks
// dirty pushed-out blocks for the next level.
// Assumes the cache never inserts an address already resident here or pending
// write-back, and never inserts the address it probes in the same cycle.
module victim_store #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 26,
    parameter int DATA_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [DATA_W-1:0] ins_data,
    input  logic              ins_dirty,
    input  logic              probe_valid,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit,
    output logic [DATA_W-1:0] probe_data,
    output logic              probe_dirty,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);
    import victim_store_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);

    // Entry storage
    logic [ENTRIES-1:0] valid_q;
    logic [ADDR_W-1:0]  addr_q  [ENTRIES];
    logic [DATA_W-1:0]  data_q  [ENTRIES];
    logic [ENTRIES-1:0] dirty_q;

    // Lookup and selection
    logic [ENTRIES-1:0] match_vec;
    logic               buf_hit;
    logic [IDX_W-1:0]   match_idx;
    logic               free_found;
    logic [IDX_W-1:0]   free_idx;
    logic [ENTRIES-1:0] oldest_vec;
    logic               old_found;
    logic [IDX_W-1:0]   old_idx;

    // Control
    logic               probe_hit_buf;
    logic               probe_hit_wb;
    logic               ins_fire;
    logic               remove;
    logic               wb_load;
    place_e             place;
    logic [IDX_W-1:0]   place_slot;

    vs_match #(
        .ENTRIES (ENTRIES),
        .ADDR_W  (ADDR_W)
    ) u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (valid_q),
        .tags  (addr_q),
        .key   (probe_addr),
        .match (match_vec),
        .any   (buf_hit),
        .idx   (match_idx)
    );

    vs_pick #(
        .ENTRIES (ENTRIES)
    ) u_free (
        .vec   (~valid_q),
        .found (free_found),
        .idx   (free_idx)
    );

    vs_order #(
        .ENTRIES (ENTRIES)
    ) u_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (valid_q),
        .push       (place != PLACE_NONE),
        .push_slot  (place_slot),
        .pop        (remove),
        .pop_slot   (match_idx),
        .oldest_vec (oldest_vec)
    );

    vs_pick #(
        .ENTRIES (ENTRIES)
    ) u_oldest (
        .vec   (oldest_vec),
        .found (old_found),
        .idx   (old_idx)
    );

    vs_holding #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wb_load),
        .load_addr (addr_q[old_idx]),
        .load_data (data_q[old_idx]),
        .cancel    (probe_hit_wb),
        .out_ready (wb_ready),
        .out_valid (wb_valid),
        .out_addr  (wb_addr),
        .out_data  (wb_data)
    );

    // Handshake and hit qualification
    always_comb begin
        probe_hit_buf = probe_valid && buf_hit;
        probe_hit_wb  = probe_valid && wb_valid && (wb_addr == probe_addr);
        ins_ready     = !wb_valid;
        ins_fire      = ins_valid && ins_ready;
        remove        = probe_hit_buf && !ins_fire;
    end

    // Choose the slot for an accepted insert: swap, then free, then oldest
    always_comb begin
        place      = PLACE_NONE;
        place_slot = '0;
        if (ins_fire) begin
            if (probe_hit_buf) begin
                place      = PLACE_SWAP;
                place_slot = match_idx;
            end else if (free_found) begin
                place      = PLACE_FREE;
                place_slot = free_idx;
            end else if (old_found) begin
                place      = PLACE_OLDEST;
                place_slot = old_idx;
            end
        end
        wb_load = (place == PLACE_OLDEST) && dirty_q[old_idx];
    end

    // Probe response from an entry, the write-back register, or nothing
    always_comb begin
        probe_hit   = probe_hit_buf || probe_hit_wb;
        probe_data  = '0;
        probe_dirty = 1'b0;
        if (probe_hit_buf) begin
            probe_data  = data_q[match_idx];
            probe_dirty = dirty_q[match_idx];
        end else if (probe_hit_wb) begin
            probe_data  = wb_data;
            probe_dirty = 1'b1;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        // Entry valid and dirty flags: set by placement, cleared by removal
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                dirty_q[g] <= 1'b0;
            end else if ((place != PLACE_NONE) && (place_slot == IDX_W'(g))) begin
                valid_q[g] <= 1'b1;
                dirty_q[g] <= ins_dirty;
            end else if (remove && (match_idx == IDX_W'(g))) begin
                valid_q[g] <= 1'b0;
            end
        end

        // Entry address and payload capture on placement
        always_ff @(posedge clk) begin
            if ((place != PLACE_NONE) && (place_slot == IDX_W'(g))) begin
                addr_q[g] <= ins_addr;
                data_q[g] <= ins_data;
            end
        end
    end

    AST_FILL_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_fire && !probe_hit_buf && free_found) |=>
            ($countones(valid_q) == $past($countones(valid_q)) + 1)); // R4

    AST_REMOVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_hit_buf && !ins_fire) |=> !valid_q[$past(match_idx)]); // R3

    AST_SWAP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_fire && probe_hit_buf) |=>
            (valid_q[$past(match_idx)] &&
             (addr_q[$past(match_idx)] == $past(ins_addr)))); // R5

    AST_CANCEL_WITHDRAWS: assert property (@(posedge clk) disable iff (!rst_n)
        probe_hit_wb |=> !wb_valid); // R9
endmodule

// File: tb/victim_store_bench.sv
// Cycle-by-cycle reference model (queue in insertion order plus one parked
// write-back) compared against the buffer's outputs every clock.
module victim_store_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 8;
    localparam int ADDR_W     = 26;
    localparam int DATA_W     = 64;
    localparam int WATCHDOG   = 100000;
    localparam int RAND_STEPS = 3000;
    localparam int POOL       = 24;

    typedef struct {
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
        logic              dirty;
    } blk_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ins_valid = 1'b0;
    logic              ins_ready;
    logic [ADDR_W-1:0] ins_addr = '0;
    logic [DATA_W-1:0] ins_data = '0;
    logic              ins_dirty = 1'b0;
    logic              probe_valid = 1'b0;
    logic [ADDR_W-1:0] probe_addr = '0;
    logic              probe_hit;
    logic [DATA_W-1:0] probe_data;
    logic              probe_dirty;
    logic              wb_valid;
    logic              wb_ready = 1'b0;
    logic [ADDR_W-1:0] wb_addr;
    logic [DATA_W-1:0] wb_data;

    blk_t fifo[$];
    bit   evp = 0;
    blk_t evb;
    int   n_cmp = 0;
    int   n_bad = 0;
    int   salt  = 0;
    bit   done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    victim_store #(
        .ENTRIES (ENTRIES),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_victim_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .ins_valid   (ins_valid),
        .ins_ready   (ins_ready),
        .ins_addr    (ins_addr),
        .ins_data    (ins_data),
        .ins_dirty   (ins_dirty),
        .probe_valid (probe_valid),
        .probe_addr  (probe_addr),
        .probe_hit   (probe_hit),
        .probe_data  (probe_data),
        .probe_dirty (probe_dirty),
        .wb_valid    (wb_valid),
        .wb_ready    (wb_ready),
        .wb_addr     (wb_addr),
        .wb_data     (wb_data)
    );

    function automatic logic [ADDR_W-1:0] addr_of(int i);
        return ADDR_W'(32'h0200 + i * 13);
    endfunction

    function automatic blk_t mk(int i, bit dty);
        blk_t b;
        salt++;
        b.a     = addr_of(i);
        b.d     = {32'(i) ^ 32'hC0DE_0000, 32'(salt * 977 + 5)};
        b.dirty = dty;
        return b;
    endfunction

    task automatic chk(string tag, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit resident(logic [ADDR_W-1:0] a);
        foreach (fifo[k]) if (fifo[k].a == a) return 1;
        return evp && (evb.a == a);
    endfunction

    // One clock: drive, compare expected outputs, advance the model
    task automatic step(string tag, bit iv, blk_t ib, bit pv, logic [ADDR_W-1:0] pa, bit er);
        int   hit_i;
        bit   hit_ev;
        bit   acc;
        bit   e_hit;
        bit   e_dirty;
        logic [DATA_W-1:0] e_data;
        @(negedge clk);
        ins_valid   = iv;
        ins_addr    = ib.a;
        ins_data    = ib.d;
        ins_dirty   = ib.dirty;
        probe_valid = pv;
        probe_addr  = pa;
        wb_ready    = er;
        #1;
        hit_i = -1;
        if (pv) foreach (fifo[k]) if (fifo[k].a == pa) hit_i = k;
        hit_ev  = pv && evp && (evb.a == pa);
        e_hit   = (hit_i >= 0) || hit_ev;
        e_data  = '0;
        e_dirty = 1'b0;
        if (hit_i >= 0) begin
            e_data  = fifo[hit_i].d;
            e_dirty = fifo[hit_i].dirty;
        end else if (hit_ev) begin
            e_data  = evb.d;
            e_dirty = 1'b1;
        end
        chk(tag, "probe_hit", DATA_W'(probe_hit), DATA_W'(e_hit));
        chk(tag, "probe_data", probe_data, e_data);
        chk(tag, "probe_dirty", DATA_W'(probe_dirty), DATA_W'(e_dirty));
        chk(tag, "ins_ready", DATA_W'(ins_ready), DATA_W'(!evp));
        chk(tag, "wb_valid", DATA_W'(wb_valid), DATA_W'(evp));
        if (evp) begin
            chk(tag, "wb_addr", DATA_W'(wb_addr), DATA_W'(evb.a));
            chk(tag, "wb_data", wb_data, evb.d);
        end
        // Model update for the coming edge
        acc = iv && !evp;
        if (evp && (er || hit_ev)) evp = 0;
        if (hit_i >= 0) begin
            fifo.delete(hit_i);
            if (acc) fifo.push_back(ib);
        end else if (acc) begin
            if (fifo.size() == ENTRIES) begin
                blk_t old;
                old = fifo.pop_front();
                if (old.dirty) begin
                    evp = 1;
                    evb = old;
                end
            end
            fifo.push_back(ib);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        blk_t nb;
        nb = mk(99, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        step("R1", 0, nb, 0, '0, 0);
        step("R1", 0, nb, 1, addr_of(3), 0);

        // R4: fill all slots, odd indices dirty
        for (int i = 0; i < ENTRIES; i++) step("R4", 1, mk(i, i % 2), 0, '0, 0);
        // R2: hit returns the block; R3: a repeat misses
        step("R2", 0, nb, 1, addr_of(3), 0);
        step("R3", 0, nb, 1, addr_of(3), 0);
        step("R2", 0, nb, 1, addr_of(30), 0);

        // R6: the freed slot is reused without a push-out
        step("R6", 1, mk(8, 0), 0, '0, 0);
        // R7: the oldest entry (clean) is dropped
        step("R7", 1, mk(9, 1), 0, '0, 0);
        step("R6", 0, nb, 1, addr_of(0), 0);
        // R7: the oldest entry (dirty) is parked and held
        step("R7", 1, mk(10, 0), 0, '0, 0);
        step("R7", 0, nb, 0, '0, 0);
        // R8: an insert offered during the stall is not taken
        step("R8", 1, mk(11, 1), 0, '0, 0);
        step("R8", 0, nb, 1, addr_of(11), 0);
        step("R7", 0, nb, 0, '0, 1);
        step("R7", 0, nb, 0, '0, 0);

        // R9: take back the parked block
        step("R6", 1, mk(11, 1), 0, '0, 0);
        step("R6", 1, mk(12, 0), 0, '0, 0);
        step("R7", 1, mk(13, 1), 0, '0, 0);
        step("R9", 0, nb, 1, addr_of(5), 0);
        step("R9", 0, nb, 0, '0, 0);

        // R5: swap on a full buffer, then show the swapped-in block is newest
        step("R5", 1, mk(14, 0), 1, addr_of(8), 0);
        step("R5", 0, nb, 0, '0, 0);
        step("R6", 1, mk(15, 1), 0, '0, 0);
        step("R6", 1, mk(16, 0), 0, '0, 0);
        step("R7", 0, nb, 0, '0, 1);
        step("R6", 0, nb, 1, addr_of(7), 0);
        step("R5", 0, nb, 1, addr_of(14), 0);

        // R2: mixed random traffic over a small address pool
        for (int n = 0; n < RAND_STEPS; n++) begin
            bit   pv;
            bit   iv;
            bit   er;
            int   pi;
            int   ii;
            blk_t b;
            pv = ($urandom % 2) == 0;
            pi = int'($urandom % POOL);
            ii = int'($urandom % POOL);
            iv = ($urandom % 3) != 0;
            er = ($urandom % 4) != 0;
            if (resident(addr_of(ii)) || (ii == pi)) iv = 0;
            b = mk(ii, bit'($urandom % 2));
            step("R2", iv, b, pv, addr_of(pi), er);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule